// File: doc/BRIEF.md
# Index-Prefix Second-Byte Decoder

This block decodes the opcode byte that follows an index-register prefix in an 8-bit processor core. Each opcode is turned into a small control word: an operation class, a destination and a source operand selector, a three-bit ALU function and the total cycle count of the instruction, prefix fetch included. The execution stage uses this word to drive its datapath.

Three features separate the indexed decode from the plain one. Register moves and ALU operations that name H or L in the plain set work on the high or low half of the index register here. Forms that name the memory operand use the displaced index address, and in those forms H and L remain the real registers. Every instruction class has its own cycle count. Opcode 0xCB is passed to the bit-operation sub-prefix path. Opcodes with no indexed meaning are forwarded to the plain decoder.

The caller presents a byte with a one-cycle strobe. The decoded word appears one clock later and stays unchanged until the next strobe.

Top module: `idx_op_decode`

## Requirements
- R1: After reset `dec_vld`, `to_bitops` and `fallback` are 0. `dec_class` is 0, `alu_op` is 0, `cycles` is 0, `fwd_code` is 0, and both selectors hold 31 (none).
- R2: A strobe on `op_valid` registers the decode of `op_code` at the next clock edge and pulses `dec_vld` for one cycle. Without a strobe, every decode output holds its value.
- R3: Opcodes 0x09, 0x19, 0x29 and 0x39 decode as class 2 (16-bit add), with destination 14 (whole index register) and cycles 15. The source is 12 (BC), 13 (DE), 14 (index) or 15 (SP), in that order.
- R4: Whole-index operations:
  - Class 3 (16-bit load) covers 0x21 (14←6 immediate, 14 cycles), 0x22 (11 absolute memory←14, 20 cycles), 0x2A (14←11, 20 cycles) and 0xF9 (15←14, 10 cycles).
  - Class 4 covers 0x23 (alu_op 0, increment) and 0x2B (alu_op 1, decrement), each 10 cycles on selector 14.
  - Class 8 (stack) covers 0xE1 pop (alu_op 0, 14←16, 14 cycles), 0xE5 push (alu_op 1, 16←14, 15 cycles) and 0xE3 exchange (alu_op 2, 14←16, 23 cycles).
  - Class 9 covers 0xE9 jump (source 14, destination 31, 8 cycles).
- R5: Half-register forms, with selector 8 for the index high half and 9 for the low half:
  - 0x24/0x25/0x2C/0x2D are class 5 increments (alu_op 0) or decrements (alu_op 1), 8 cycles.
  - 0x26/0x2E are class 6 loads from immediate (6), 11 cycles.
  - In 0x40–0x7F, when either 3-bit field is 4 or 5 and neither is 6, the move is class 6 with fields 4 and 5 replaced by selectors 8 and 9, 8 cycles.
- R6: In 0x40–0x7F (not 0x76), when one field is 6 the other operand is the real register (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 A) and the memory side is selector 10. The result is class 6, 19 cycles. 0x36 is class 6, 10←6, 19 cycles.
- R7: 0x34 and 0x35 are class 5 on selector 10 with alu_op 0 and 1 respectively, 23 cycles.
- R8: In 0x80–0xBF, bits [5:3] go to `alu_op` (0 ADD … 7 CP) with class 7 and destination 7 (A). A low field of 4 gives source 8, 5 gives source 9 (both 8 cycles), and 6 gives source 10 (19 cycles).
- R9: 0xCB gives class 10 with `to_bitops`=1, `fallback`=0, cycles 0 and both selectors 31.
- R10: 0x00 gives class 1 (extended no-op), 8 cycles, both selectors 31.
- R11: Every other opcode, including 0x76 and register-only forms, gives `fallback`=1 and `fwd_code` equal to the opcode. In that case class, alu_op and cycles are 0 and the selectors are 31. `fwd_code` is 0 whenever `fallback` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Strobe: `op_code` holds a byte to decode |
| op_code | input | 8 | Opcode byte after the index prefix |
| dec_vld | output | 1 | One-cycle pulse: new decode registered |
| dec_class | output | 4 | Operation class |
| dst_sel | output | 5 | Destination operand selector |
| src_sel | output | 5 | Source operand selector |
| alu_op | output | 3 | ALU function or sub-operation |
| cycles | output | 5 | Total instruction cycles |
| to_bitops | output | 1 | Byte goes to the bit-operation sub-prefix path |
| fallback | output | 1 | Byte goes to the plain decoder |
| fwd_code | output | 8 | Forwarded opcode when `fallback` is set |

## Verification
The hardest region to cover is the 0x40–0x7F move block. Within it, the same field values 4 and 5 mean index halves in one opcode and real H and L in another, depending only on whether the other field is 6. Next to these sit fallback forms such as 0x41 and the 0x76 hole. The stimulus places opcodes that differ by a single field on either side of each boundary: 0x44 vs 0x41, 0x66 vs 0x65, 0x74 vs 0x76. It also checks, after idle cycles, that a decode is held.

// File: rtl/idx_op_decode.sv
module idx_op_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  output logic       dec_vld,
  output logic [3:0] dec_class,
  output logic [4:0] dst_sel,
  output logic [4:0] src_sel,
  output logic [2:0] alu_op,
  output logic [4:0] cycles,
  output logic       to_bitops,
  output logic       fallback,
  output logic [7:0] fwd_code
);

  localparam logic [3:0] C_PLAIN = 4'd0, C_XNOP = 4'd1, C_ADD16 = 4'd2, C_LD16 = 4'd3,
                         C_IDW = 4'd4, C_ID8 = 4'd5, C_MOV8 = 4'd6, C_ALU8 = 4'd7,
                         C_STK = 4'd8, C_JMP = 4'd9, C_BITP = 4'd10;
  localparam logic [4:0] S_IMM = 5'd6, S_A = 5'd7, S_IH = 5'd8, S_IL = 5'd9, S_MEMD = 5'd10,
                         S_ABS = 5'd11, S_BC = 5'd12, S_DE = 5'd13, S_IDX = 5'd14,
                         S_SP = 5'd15, S_STK = 5'd16, S_NONE = 5'd31;

  logic [3:0] n_cls;
  logic [4:0] n_dst, n_src, n_cyc;
  logic [2:0] n_alu;
  logic       n_bit, n_fb;

  wire [2:0] fd = op_code[5:3];
  wire [2:0] fs = op_code[2:0];

  function automatic logic [4:0] half_map(input logic [2:0] r);
    case (r)
      3'd4:    half_map = S_IH;
      3'd5:    half_map = S_IL;
      default: half_map = {2'b00, r};
    endcase
  endfunction

  function automatic logic [4:0] pair_map(input logic [1:0] p);
    case (p)
      2'd0:    pair_map = S_BC;
      2'd1:    pair_map = S_DE;
      2'd2:    pair_map = S_IDX;
      default: pair_map = S_SP;
    endcase
  endfunction

  always_comb begin
    n_cls = C_PLAIN;
    n_dst = S_NONE;
    n_src = S_NONE;
    n_alu = 3'd0;
    n_cyc = 5'd0;
    n_bit = 1'b0;
    n_fb  = 1'b0;
    if (op_code[7:6] == 2'b01) begin
      if (op_code == 8'h76) n_fb = 1'b1;
      else if (fs == 3'd6) begin
        n_cls = C_MOV8; n_dst = {2'b00, fd}; n_src = S_MEMD; n_cyc = 5'd19;
      end else if (fd == 3'd6) begin
        n_cls = C_MOV8; n_dst = S_MEMD; n_src = {2'b00, fs}; n_cyc = 5'd19;
      end else if (fd[2:1] == 2'b10 || fs[2:1] == 2'b10) begin
        n_cls = C_MOV8; n_dst = half_map(fd); n_src = half_map(fs); n_cyc = 5'd8;
      end else n_fb = 1'b1;
    end else if (op_code[7:6] == 2'b10) begin
      if (fs == 3'd4 || fs == 3'd5 || fs == 3'd6) begin
        n_cls = C_ALU8; n_dst = S_A; n_alu = fd;
        n_src = (fs == 3'd6) ? S_MEMD : half_map(fs);
        n_cyc = (fs == 3'd6) ? 5'd19 : 5'd8;
      end else n_fb = 1'b1;
    end else if (op_code[7:6] == 2'b00 && op_code[3:0] == 4'h9) begin
      n_cls = C_ADD16; n_dst = S_IDX; n_src = pair_map(op_code[5:4]); n_cyc = 5'd15;
    end else begin
      case (op_code)
        8'h00: begin n_cls = C_XNOP; n_cyc = 5'd8; end
        8'h21: begin n_cls = C_LD16; n_dst = S_IDX; n_src = S_IMM; n_cyc = 5'd14; end
        8'h22: begin n_cls = C_LD16; n_dst = S_ABS; n_src = S_IDX; n_cyc = 5'd20; end
        8'h2A: begin n_cls = C_LD16; n_dst = S_IDX; n_src = S_ABS; n_cyc = 5'd20; end
        8'hF9: begin n_cls = C_LD16; n_dst = S_SP;  n_src = S_IDX; n_cyc = 5'd10; end
        8'h23, 8'h2B: begin
          n_cls = C_IDW; n_dst = S_IDX; n_src = S_IDX; n_alu = {2'b00, op_code[3]}; n_cyc = 5'd10;
        end
        8'h24, 8'h25, 8'h2C, 8'h2D: begin
          n_cls = C_ID8; n_dst = op_code[3] ? S_IL : S_IH; n_src = n_dst;
          n_alu = {2'b00, op_code[0]}; n_cyc = 5'd8;
        end
        8'h26, 8'h2E: begin
          n_cls = C_MOV8; n_dst = op_code[3] ? S_IL : S_IH; n_src = S_IMM; n_cyc = 5'd11;
        end
        8'h34, 8'h35: begin
          n_cls = C_ID8; n_dst = S_MEMD; n_src = S_MEMD; n_alu = {2'b00, op_code[0]}; n_cyc = 5'd23;
        end
        8'h36: begin n_cls = C_MOV8; n_dst = S_MEMD; n_src = S_IMM; n_cyc = 5'd19; end
        8'hE1: begin n_cls = C_STK; n_dst = S_IDX; n_src = S_STK; n_alu = 3'd0; n_cyc = 5'd14; end
        8'hE5: begin n_cls = C_STK; n_dst = S_STK; n_src = S_IDX; n_alu = 3'd1; n_cyc = 5'd15; end
        8'hE3: begin n_cls = C_STK; n_dst = S_IDX; n_src = S_STK; n_alu = 3'd2; n_cyc = 5'd23; end
        8'hE9: begin n_cls = C_JMP; n_src = S_IDX; n_cyc = 5'd8; end
        8'hCB: begin n_cls = C_BITP; n_bit = 1'b1; end
        default: n_fb = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_vld   <= 1'b0;
      dec_class <= C_PLAIN;
      dst_sel   <= S_NONE;
      src_sel   <= S_NONE;
      alu_op    <= 3'd0;
      cycles    <= 5'd0;
      to_bitops <= 1'b0;
      fallback  <= 1'b0;
      fwd_code  <= 8'h00;
    end else begin
      dec_vld <= op_valid;
      if (op_valid) begin
        dec_class <= n_cls;
        dst_sel   <= n_dst;
        src_sel   <= n_src;
        alu_op    <= n_alu;
        cycles    <= n_cyc;
        to_bitops <= n_bit;
        fallback  <= n_fb;
        fwd_code  <= n_fb ? op_code : 8'h00;
      end
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> dec_vld); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({dec_class, dst_sel, src_sel, alu_op, cycles, to_bitops, fallback, fwd_code})); // R2
  AST_ADD16_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code[7:6] == 2'b00 && op_code[3:0] == 4'h9 |=> dst_sel == S_IDX && cycles == 5'd15); // R3
  AST_MEM_INCDEC: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 8'h34 || op_code == 8'h35) |=> cycles == 5'd23 && dst_sel == S_MEMD); // R7
  AST_ALU_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code[7:6] == 2'b10 && op_code[2:0] == 3'd6 |=> cycles == 5'd19 && alu_op == $past(op_code[5:3])); // R8
  AST_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({to_bitops, fallback})); // R9
  AST_FB_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld && fallback |-> fwd_code == $past(op_code) && cycles == 5'd0); // R11

endmodule

// File: tb/idx_op_decode_test.sv
module idx_op_decode_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic       dec_vld, to_bitops, fallback;
  logic [3:0] dec_class;
  logic [4:0] dst_sel, src_sel, cycles;
  logic [2:0] alu_op;
  logic [7:0] fwd_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [4:0] NONE = 5'd31;

  idx_op_decode uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dec_vld(dec_vld), .dec_class(dec_class), .dst_sel(dst_sel), .src_sel(src_sel),
    .alu_op(alu_op), .cycles(cycles), .to_bitops(to_bitops), .fallback(fallback),
    .fwd_code(fwd_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_all(input string req, input int cls, input int dst, input int src,
                            input int alu, input int cyc, input int bitp, input int fb, input int fwd);
    cmp(req, "class", dec_class, cls);
    cmp(req, "dst", dst_sel, dst);
    cmp(req, "src", src_sel, src);
    cmp(req, "alu", alu_op, alu);
    cmp(req, "cycles", cycles, cyc);
    cmp(req, "to_bitops", to_bitops, bitp);
    cmp(req, "fallback", fallback, fb);
    cmp(req, "fwd", fwd_code, fwd);
  endtask

  task automatic strobe(input logic [7:0] b);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = b;
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = 8'h5A;
    cmp("R2", "dec_vld", dec_vld, 1);
  endtask

  task automatic dec(input string req, input logic [7:0] b, input int cls, input int dst,
                     input int src, input int alu, input int cyc);
    strobe(b);
    expect_all(req, cls, dst, src, alu, cyc, 0, 0, 0);
  endtask

  task automatic plain(input string req, input logic [7:0] b);
    strobe(b);
    expect_all(req, 0, NONE, NONE, 0, 0, 0, 1, b);
  endtask

  task automatic t_reset;
    expect_all("R1", 0, NONE, NONE, 0, 0, 0, 0, 0);
    cmp("R1", "dec_vld", dec_vld, 0);
  endtask

  task automatic t_add16;
    dec("R3", 8'h09, 2, 14, 12, 0, 15);
    dec("R3", 8'h19, 2, 14, 13, 0, 15);
    dec("R3", 8'h29, 2, 14, 14, 0, 15);
    dec("R3", 8'h39, 2, 14, 15, 0, 15);
  endtask

  task automatic t_whole;
    dec("R4", 8'h21, 3, 14, 6, 0, 14);
    dec("R4", 8'h22, 3, 11, 14, 0, 20);
    dec("R4", 8'h2A, 3, 14, 11, 0, 20);
    dec("R4", 8'hF9, 3, 15, 14, 0, 10);
    dec("R4", 8'h23, 4, 14, 14, 0, 10);
    dec("R4", 8'h2B, 4, 14, 14, 1, 10);
    dec("R4", 8'hE1, 8, 14, 16, 0, 14);
    dec("R4", 8'hE5, 8, 16, 14, 1, 15);
    dec("R4", 8'hE3, 8, 14, 16, 2, 23);
    dec("R4", 8'hE9, 9, NONE, 14, 0, 8);
  endtask

  task automatic t_halves;
    dec("R5", 8'h24, 5, 8, 8, 0, 8);
    dec("R5", 8'h2D, 5, 9, 9, 1, 8);
    dec("R5", 8'h26, 6, 8, 6, 0, 11);
    dec("R5", 8'h2E, 6, 9, 6, 0, 11);
    dec("R5", 8'h44, 6, 0, 8, 0, 8);
    dec("R5", 8'h65, 6, 8, 9, 0, 8);
    dec("R5", 8'h6F, 6, 9, 7, 0, 8);
    dec("R5", 8'h64, 6, 8, 8, 0, 8);
  endtask

  task automatic t_memmove;
    dec("R6", 8'h66, 6, 4, 10, 0, 19);
    dec("R6", 8'h6E, 6, 5, 10, 0, 19);
    dec("R6", 8'h74, 6, 10, 4, 0, 19);
    dec("R6", 8'h7E, 6, 7, 10, 0, 19);
    dec("R6", 8'h36, 6, 10, 6, 0, 19);
  endtask

  task automatic t_memincdec;
    dec("R7", 8'h34, 5, 10, 10, 0, 23);
    dec("R7", 8'h35, 5, 10, 10, 1, 23);
  endtask

  task automatic t_alu;
    dec("R8", 8'h86, 7, 7, 10, 0, 19);
    dec("R8", 8'h8C, 7, 7, 8, 1, 8);
    dec("R8", 8'h9D, 7, 7, 9, 3, 8);
    dec("R8", 8'hAE, 7, 7, 10, 5, 19);
    dec("R8", 8'hBC, 7, 7, 8, 7, 8);
  endtask

  task automatic t_special;
    strobe(8'hCB);
    expect_all("R9", 10, NONE, NONE, 0, 0, 1, 0, 0);
    dec("R10", 8'h00, 1, NONE, NONE, 0, 8);
  endtask

  task automatic t_plain;
    plain("R11", 8'h41);
    plain("R11", 8'h76);
    plain("R11", 8'hA8);
    plain("R11", 8'hC3);
    plain("R11", 8'h01);
    dec("R11", 8'h09, 2, 14, 12, 0, 15);
  endtask

  task automatic t_hold;
    strobe(8'hE3);
    repeat (3) @(negedge clk);
    cmp("R2", "dec_vld idle", dec_vld, 0);
    expect_all("R2", 8, 14, 16, 2, 23, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_add16;
    t_whole;
    t_halves;
    t_memmove;
    t_memincdec;
    t_alu;
    t_special;
    t_plain;
    t_hold;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule